// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer with a one-shot configuration register. Software may read an 8-bit mode register at any time. The register picks the counting source and the overflow period. Only the first write after reset is accepted, so a runaway program cannot later disable or stretch the watchdog.

Two tick-enable inputs feed the counter. One comes from an internal oscillator and the other from an external crystal, both already brought into the system clock domain. A separate key port restarts the count: the agreed key value clears the counter, and any other value fires the watchdog reset at once. When the counter has seen the number of ticks that the period selects, the block drives a one-cycle reset pulse and starts counting again from zero. A strap input can pin the source to the internal oscillator, so that the watchdog cannot be stopped.

No data stream passes through the block. Every write port is a single-cycle strobe that is always accepted, so there is no valid/ready handshake and no back-pressure. All outputs are plain control and status pins.

Top module: `wdt_guard`

## Requirements
- R1: After reset the mode register reads 0x67, and the reset output is low.
- R2: Bits 7..5 of the mode register always read 3'b011, and writes to them are ignored. Bits 4..0 read back the value that was accepted.
- R3: Only the first mode write after reset is accepted. Any later write leaves both the readback and the counter untouched.
- R4: Bits 4..3 equal to 00 or 01 select the internal tick. The overflow then comes after 2^(11+n) internal ticks, where n is bits 2..0.
- R5: Bits 4..3 equal to 10 select the external tick. The overflow then comes after 2^(13+n) external ticks, and internal ticks are not counted.
- R6: Bits 4..3 equal to 11 stop the watchdog when the strap is low. No tick is counted and no overflow occurs.
- R7: When the lock strap is high, the internal tick and the internal period scaling are used, whatever bits 4..3 hold.
- R8: A key write of 0xAC clears the counter without a reset. A key write of any other value drives the reset output in the cycle after the write and clears the counter.
- R9: The overflow pulse lasts one cycle. The counter restarts from zero, so the next overflow follows one full period later.
- R10: An accepted mode write clears the counter, so the new period is counted in full from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_int_osc | input | 1 | Strap: force the internal tick source |
| int_tick | input | 1 | Internal oscillator tick enable |
| ext_tick | input | 1 | External crystal tick enable |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_data | input | 8 | Mode register write value |
| mode_rd_data | output | 8 | Mode register readback |
| key_wr_en | input | 1 | Key register write strobe |
| key_wr_data | input | 8 | Key register write value |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The mode readback changes at the clock edge that samples the accepted write, and the bench reads it at the falling edge that follows. A write sampled at edge E clears the counter. With a tick present in every cycle, the overflow pulse is then visible after edge E+P, and when the tick starts at edge S the pulse follows edge S+P-1. A rejected key sampled at edge E shows the pulse right after edge E. The driver pushes these exact cycle numbers into a queue. The monitor pops one entry for every pulse it sees on a falling edge. It reports any pulse that arrives early or that nobody expected, and a drain check at the end of each test catches a pulse that never came.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int MODE_W = 8;
  localparam int SEL_W  = 3;
  localparam logic [MODE_W-1:0] MODE_RST = 8'h67;
  localparam logic [2:0]        FIXED_HI = 3'b011;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_OFF = 2'd2
  } src_e;

  typedef struct packed {
    logic [1:0]       clk_sel;
    logic [SEL_W-1:0] per_sel;
  } mode_t;
endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
  import wdt_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output mode_t             mode,
  output logic [MODE_W-1:0] rd_data,
  output logic              load
);
  logic written;

  // a write is accepted only while no earlier one has landed
  assign load = wr_en && !written;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= mode_t'(MODE_RST[4:0]);
      written <= 1'b0;
    end else if (load) begin
      mode    <= mode_t'(wr_data[4:0]);
      written <= 1'b1;
    end
  end

  assign rd_data = {FIXED_HI, mode};

  p_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    written |=> $stable(mode));
  p_load_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (written && !load));
  p_hi_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:5] != FIXED_HI) |=> (rd_data[7:5] == FIXED_HI));
endmodule

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
  import wdt_guard_pkg::*;
#(
  parameter int INT_EXP = 11,
  parameter int EXT_EXP = 13,
  parameter int EXP_W   = 5
) (
  input  logic             lock_int,
  input  mode_t            mode,
  input  logic             int_tick,
  input  logic             ext_tick,
  output logic             tick,
  output logic [EXP_W-1:0] exp_sel
);
  src_e src;

  always_comb begin
    if (lock_int) begin
      src = SRC_INT;
    end else begin
      unique case (mode.clk_sel)
        2'b10:   src = SRC_EXT;
        2'b11:   src = SRC_OFF;
        default: src = SRC_INT;
      endcase
    end
  end

  always_comb begin
    unique case (src)
      SRC_INT: tick = int_tick;
      SRC_EXT: tick = ext_tick;
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    if (src == SRC_EXT) exp_sel = EXP_W'(EXT_EXP) + EXP_W'(mode.per_sel);
    else                exp_sel = EXP_W'(INT_EXP) + EXP_W'(mode.per_sel);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int          CNT_W = 20,
  parameter int          EXP_W = 5,
  parameter logic [7:0]  KEY   = 8'hAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             clear,
  input  logic             key_wr_en,
  input  logic [7:0]       key_wr_data,
  output logic             wdt_rst
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;

  // 2^exp - 1; for exp == CNT_W the shift wraps to 0, giving all ones
  assign term = (CNT_W'(1) << exp_sel) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= 1'b0;
      if (key_wr_en) begin
        cnt     <= '0;
        wdt_rst <= (key_wr_data != KEY);
      end else if (clear) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == term) begin
          cnt     <= '0;
          wdt_rst <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  p_key_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en |=> (cnt == '0));
  p_bad_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_en && key_wr_data != KEY) |=> wdt_rst);
  p_good_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_en && key_wr_data == KEY) |=> !wdt_rst);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (cnt == '0));
  p_cfg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear && !key_wr_en) |=> ($stable(cnt) && !wdt_rst));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int         INT_EXP = 11,
  parameter int         EXT_EXP = 13,
  parameter logic [7:0] KEY     = 8'hAC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_int_osc,
  input  logic       int_tick,
  input  logic       ext_tick,
  input  logic       mode_wr_en,
  input  logic [7:0] mode_wr_data,
  output logic [7:0] mode_rd_data,
  input  logic       key_wr_en,
  input  logic [7:0] key_wr_data,
  output logic       wdt_rst
);
  localparam int BASE_MAX = (INT_EXP > EXT_EXP) ? INT_EXP : EXT_EXP;
  localparam int MAX_EXP  = BASE_MAX + (1 << SEL_W) - 1;
  localparam int CNT_W    = MAX_EXP;
  localparam int EXP_W    = $clog2(MAX_EXP + 1);

  mode_t            mode;
  logic             cfg_load;
  logic             sel_tick;
  logic [EXP_W-1:0] exp_sel;

  wdt_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode    (mode),
    .rd_data (mode_rd_data),
    .load    (cfg_load)
  );

  wdt_src_sel #(
    .INT_EXP (INT_EXP),
    .EXT_EXP (EXT_EXP),
    .EXP_W   (EXP_W)
  ) u_src (
    .lock_int (lock_int_osc),
    .mode     (mode),
    .int_tick (int_tick),
    .ext_tick (ext_tick),
    .tick     (sel_tick),
    .exp_sel  (exp_sel)
  );

  p_lock_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_int_osc |-> (sel_tick == int_tick));
  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_int_osc && mode_rd_data[4:3] == 2'b11) |-> !sel_tick);
  p_ext_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_int_osc && mode_rd_data[4:3] == 2'b10) |-> (sel_tick == ext_tick));

  wdt_counter #(
    .CNT_W (CNT_W),
    .EXP_W (EXP_W),
    .KEY   (KEY)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (sel_tick),
    .exp_sel     (exp_sel),
    .clear       (cfg_load),
    .key_wr_en   (key_wr_en),
    .key_wr_data (key_wr_data),
    .wdt_rst     (wdt_rst)
  );
endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_int_osc = 1'b0;
  logic       int_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       mode_wr_en = 1'b0;
  logic [7:0] mode_wr_data = '0;
  logic [7:0] mode_rd_data;
  logic       key_wr_en = 1'b0;
  logic [7:0] key_wr_data = '0;
  logic       wdt_rst;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  int    exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_guard dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_int_osc (lock_int_osc),
    .int_tick     (int_tick),
    .ext_tick     (ext_tick),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .mode_rd_data (mode_rd_data),
    .key_wr_en    (key_wr_en),
    .key_wr_data  (key_wr_data),
    .wdt_rst      (wdt_rst)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // monitor: every pulse pops one expected cycle
  always @(negedge clk) begin
    if (rst_n && wdt_rst) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected pulse actual=%0d expected=none", cur_req, cyc);
      end else begin
        int    e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL %s pulse cycle actual=%0d expected=%0d", r, cyc, e);
        end
      end
    end
  end

  task automatic expect_pulse(input int c, input string req);
    exp_q.push_back(c);
    req_q.push_back(req);
  endtask

  task automatic drain(input string req);
    chk(req, exp_q.size(), 0);
    exp_q.delete();
    req_q.delete();
  endtask

  task automatic do_reset(input logic lock);
    @(negedge clk);
    rst_n = 1'b0;
    lock_int_osc = lock;
    int_tick = 1'b0;
    ext_tick = 1'b0;
    mode_wr_en = 1'b0;
    key_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_mode(input logic [7:0] d, output int e);
    @(negedge clk);
    mode_wr_en = 1'b1;
    mode_wr_data = d;
    e = cyc + 1;
    @(negedge clk);
    mode_wr_en = 1'b0;
  endtask

  task automatic write_key(input logic [7:0] d, output int e);
    @(negedge clk);
    key_wr_en = 1'b1;
    key_wr_data = d;
    e = cyc + 1;
    @(negedge clk);
    key_wr_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int e;
    int k;
    int b;
    int s;
    // R1: reset state
    do_reset(1'b0);
    @(negedge clk);
    chk("R1", mode_rd_data, 8'h67);
    chk("R1", wdt_rst, 0);

    // R10 / R4 / R2 / R3 / R9: run long under the reset config, then set n=0
    cur_req = "R10";
    int_tick = 1'b1;
    wait_until(cyc + 3000);
    write_mode(8'h80, e);
    chk("R2", mode_rd_data, 8'h60);
    expect_pulse(e + 2048, "R10");
    expect_pulse(e + 4096, "R9");
    wait_until(e + 1000);
    cur_req = "R3";
    write_mode(8'h1F, k);
    chk("R3", mode_rd_data, 8'h60);
    wait_until(e + 4096 + 50);
    drain("R3");

    // R8: good key restarts, bad key fires
    do_reset(1'b0);
    cur_req = "R8";
    int_tick = 1'b1;
    write_mode(8'h01, e);
    chk("R4", mode_rd_data, 8'h61);
    wait_until(e + 3000);
    write_key(8'hAC, k);
    wait_until(k + 4000);
    write_key(8'h5A, b);
    expect_pulse(b, "R8");
    expect_pulse(b + 4096, "R4");
    wait_until(b + 4096 + 50);
    drain("R8");

    // R5: external source, internal ticks ignored
    do_reset(1'b0);
    cur_req = "R5";
    int_tick = 1'b1;
    write_mode(8'h10, e);
    chk("R2", mode_rd_data, 8'h70);
    wait_until(e + 3000);
    @(negedge clk);
    ext_tick = 1'b1;
    s = cyc + 1;
    expect_pulse(s + 8191, "R5");
    wait_until(s + 8191 + 50);
    drain("R5");

    // R6: stopped
    do_reset(1'b0);
    cur_req = "R6";
    int_tick = 1'b1;
    ext_tick = 1'b1;
    write_mode(8'h18, e);
    chk("R6", mode_rd_data, 8'h78);
    wait_until(e + 10000);
    drain("R6");

    // R7: strap forces internal source and scaling
    do_reset(1'b1);
    cur_req = "R7";
    int_tick = 1'b1;
    write_mode(8'h1A, e);
    chk("R7", mode_rd_data, 8'h7A);
    expect_pulse(e + 8192, "R7");
    wait_until(e + 8192 + 50);
    drain("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule